// File: doc/BRIEF.md
# DRAM Refresh and Initialization Sequencer

This block brings an asynchronous DRAM array into service after power-on and keeps its contents alive afterwards. After reset it waits out the mandatory power-up settling time, then runs a burst of refresh cycles of the CAS-before-RAS kind. Only after that burst does it raise `ready`, which tells the access controller that normal read and write cycles may start. From then on an interval timer grants one refresh credit per refresh interval. Each owed refresh is run as one CAS-before-RAS cycle on the row and column strobes. The write-enable strobe is held high so that the memory never latches its test mode.

The strobes are shared with an access controller, so the sequencer asks for the bus with `refresh_req` and waits for `refresh_gnt`. While the grant is withheld, owed refreshes pile up in a credit counter of bounded depth. When the grant returns they are served back to back. Any tick that would push the credit past its depth sets a sticky overrun flag. Every time limit is a nanosecond figure turned into clock cycles from the `CLK_MHZ` parameter. Minimum durations are rounded up and the refresh interval is rounded down.

Top module: `dram_rfsh_seq`

## Requirements
- R1: While `rst_n` is low, `ras_n`, `cas_n` and `we_n` are high and `refresh_req`, `ready` and `overrun` are low.
- R2: After reset release, neither `refresh_req` nor any strobe is active for the power-up wait of ceil(200 us × CLK_MHZ) cycles (20000 at 100 MHz). `refresh_req` rises no more than three cycles after that wait ends.
- R3: After the wait the block runs exactly INIT_REFRESHES (8) refresh cycles with `ready` low. It then raises `ready`, which stays high until reset.
- R4: In every refresh cycle `cas_n` goes low at least ceil(10 ns) cycles (1 at 100 MHz) before `ras_n` falls.
- R5: `ras_n` stays low for max(ceil(60 ns), ceil(10 ns)) cycles (6 at 100 MHz), and `cas_n` stays low throughout that pulse.
- R6: Between two `ras_n` pulses, `ras_n` stays high for at least max(ceil(40 ns), ceil(5 ns)) cycles (4 at 100 MHz).
- R7: `cas_n` is high in the cycle in which `ras_n` rises. It does not fall again until at least one full cycle later.
- R8: `we_n` is high at all times.
- R9: The strobes move only while `refresh_req` is high. A cycle starts on a rising clock edge at which `refresh_gnt` is sampled high while the request is pending. While the grant is withheld, no strobe falls and the request stays high. The request stays high until the end of precharge.
- R10: Once `ready` is high, one refresh credit is added every floor(15.6 us × CLK_MHZ) cycles (1560 at 100 MHz). With the grant given at once, successive `ras_n` falls are exactly that many cycles apart.
- R11: Up to MAX_CREDIT (8) owed refreshes accumulate without error. A tick in the same cycle as a grant acceptance leaves the credit unchanged. When the grant returns, all owed refreshes run back to back.
- R12: A tick that arrives with MAX_CREDIT owed and no grant acceptance in that cycle sets `overrun`. `overrun` stays set until reset, and the credit stays at MAX_CREDIT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, CLK_MHZ megahertz |
| rst_n | input | 1 | Active-low synchronous reset |
| refresh_gnt | input | 1 | Bus grant from the access controller |
| refresh_req | output | 1 | Bus request, held high from request to end of precharge |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, always high |
| ready | output | 1 | Array initialized, normal accesses allowed |
| overrun | output | 1 | Sticky flag: refresh credit exceeded |

## Verification
Two functions can land on the same clock edge: the interval timer adding a credit, and the sequencer consuming one on grant acceptance. To provoke this, the bench withholds the grant after a steady refresh until eight credits are owed. It then releases the grant so that acceptance falls exactly on the edge of the ninth tick, an edge it computes from the observed refresh spacing. The outcome is judged at the pins: `overrun` must stay low, and exactly nine refresh cycles must follow before the next tick. A later window withholds the grant past the ninth tick to show the flag rising and the credit saturating at eight.

// File: rtl/dram_rfsh_pkg.sv
package dram_rfsh_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_REQ,
      ST_SETUP,
      ST_RASLO,
      ST_PRECH
   } cbr_state_t;

   // duration in ns to cycles, rounded up (minimum limits)
   function automatic int cyc_up(input int ns, input int mhz);
      return (ns * mhz + 999) / 1000;
   endfunction

   // duration in ns to cycles, rounded down (maximum limits)
   function automatic int cyc_dn(input int ns, input int mhz);
      return (ns * mhz) / 1000;
   endfunction

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/rfsh_startup.sv
module rfsh_startup #(
   parameter int PWRUP_CYC      = 20000,
   parameter int INIT_REFRESHES = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cycle_done,
   output logic init_busy,
   output logic ready
);
   localparam int PW = $clog2(PWRUP_CYC + 1);
   localparam int IW = $clog2(INIT_REFRESHES + 1);

   logic [PW-1:0] wait_cnt;
   logic [IW-1:0] init_left;
   logic          pwr_ok;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wait_cnt  <= '0;
         pwr_ok    <= 1'b0;
         init_left <= IW'(INIT_REFRESHES);
         ready     <= 1'b0;
      end else begin
         if (!pwr_ok) begin
            wait_cnt <= wait_cnt + PW'(1);
            if (wait_cnt == PW'(PWRUP_CYC - 1))
               pwr_ok <= 1'b1;
         end
         if (cycle_done && (init_left != '0)) begin
            init_left <= init_left - IW'(1);
            if (init_left == IW'(1))
               ready <= 1'b1;
         end
      end
   end

   assign init_busy = pwr_ok && (init_left != '0);

endmodule

// File: rtl/rfsh_interval.sv
module rfsh_interval #(
   parameter int REFI_CYC = 1560
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   localparam int TW = $clog2(REFI_CYC);

   logic [TW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= TW'(REFI_CYC - 1);
      end else if (run) begin
         if (cnt == '0)
            cnt <= TW'(REFI_CYC - 1);
         else
            cnt <= cnt - TW'(1);
      end
   end

   assign tick = run && (cnt == '0);

endmodule

// File: rtl/rfsh_credit.sv
module rfsh_credit #(
   parameter int MAX_CREDIT = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic take,
   output logic pending,
   output logic overrun
);
   localparam int CW = $clog2(MAX_CREDIT + 1);

   logic [CW-1:0] credit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         credit  <= '0;
         overrun <= 1'b0;
      end else if (tick && !take) begin
         if (credit == CW'(MAX_CREDIT))
            overrun <= 1'b1;
         else
            credit <= credit + CW'(1);
      end else if (take && !tick) begin
         credit <= credit - CW'(1);
      end
   end

   assign pending = (credit != '0);

endmodule

// File: rtl/rfsh_cbr_fsm.sv
module rfsh_cbr_fsm
   import dram_rfsh_pkg::*;
#(
   parameter int SETUP_CYC = 1,
   parameter int RAS_CYC   = 6,
   parameter int PRE_CYC   = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic want,
   input  logic gnt,
   output logic req,
   output logic ras_n,
   output logic cas_n,
   output logic start,
   output logic done
);
   localparam int LONGEST = max2(max2(SETUP_CYC, RAS_CYC), PRE_CYC);
   localparam int CW      = $clog2(LONGEST + 1);

   cbr_state_t    state;
   logic [CW-1:0] cnt;
   logic          last;

   assign last  = (cnt == '0);
   assign start = (state == ST_REQ) && gnt;
   assign done  = (state == ST_PRECH) && last;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         cnt   <= '0;
      end else begin
         unique case (state)
            ST_IDLE:  if (want) state <= ST_REQ;
            ST_REQ:   if (gnt) begin
                         state <= ST_SETUP;
                         cnt   <= CW'(SETUP_CYC - 1);
                      end
            ST_SETUP: if (last) begin
                         state <= ST_RASLO;
                         cnt   <= CW'(RAS_CYC - 1);
                      end else cnt <= cnt - CW'(1);
            ST_RASLO: if (last) begin
                         state <= ST_PRECH;
                         cnt   <= CW'(PRE_CYC - 1);
                      end else cnt <= cnt - CW'(1);
            ST_PRECH: if (last) state <= ST_IDLE;
                      else cnt <= cnt - CW'(1);
            default:  state <= ST_IDLE;
         endcase
      end
   end

   assign req   = (state != ST_IDLE);
   assign ras_n = (state != ST_RASLO);
   assign cas_n = !((state == ST_SETUP) || (state == ST_RASLO));

endmodule

// File: rtl/dram_rfsh_seq.sv
module dram_rfsh_seq
   import dram_rfsh_pkg::*;
#(
   parameter int CLK_MHZ        = 100,
   parameter int PWRUP_NS       = 200000,
   parameter int REFI_NS        = 15600,
   parameter int RAS_MIN_NS     = 60,
   parameter int RP_NS          = 40,
   parameter int CSR_NS         = 10,
   parameter int CHR_NS         = 10,
   parameter int RPC_NS         = 5,
   parameter int INIT_REFRESHES = 8,
   parameter int MAX_CREDIT     = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic refresh_gnt,
   output logic refresh_req,
   output logic ras_n,
   output logic cas_n,
   output logic we_n,
   output logic ready,
   output logic overrun
);
   localparam int PWRUP_CYC = cyc_up(PWRUP_NS, CLK_MHZ);
   localparam int REFI_CYC  = cyc_dn(REFI_NS, CLK_MHZ);
   localparam int SETUP_CYC = max2(cyc_up(CSR_NS, CLK_MHZ), 1);
   localparam int RAS_CYC   = max2(max2(cyc_up(RAS_MIN_NS, CLK_MHZ),
                                        cyc_up(CHR_NS, CLK_MHZ)), 1);
   localparam int PRE_CYC   = max2(max2(cyc_up(RP_NS, CLK_MHZ),
                                        cyc_up(RPC_NS, CLK_MHZ)), 1);

   if (CLK_MHZ < 1) begin : g_bad_clk
      $error("CLK_MHZ must be at least 1");
   end
   if (INIT_REFRESHES < 1) begin : g_bad_init
      $error("INIT_REFRESHES must be at least 1");
   end
   if (MAX_CREDIT < 1) begin : g_bad_credit
      $error("MAX_CREDIT must be at least 1");
   end
   if (REFI_CYC <= SETUP_CYC + RAS_CYC + PRE_CYC + 2) begin : g_bad_refi
      $error("refresh interval shorter than one refresh cycle");
   end
   if (PWRUP_CYC < 1) begin : g_bad_pwrup
      $error("power-up wait must be at least one cycle");
   end

   logic init_busy;
   logic tick;
   logic pending;
   logic start;
   logic done;
   logic want;
   logic take;

   assign want = init_busy || (ready && pending);
   assign take = start && ready;
   assign we_n = 1'b1;

   rfsh_startup #(
      .PWRUP_CYC      (PWRUP_CYC),
      .INIT_REFRESHES (INIT_REFRESHES)
   ) u_startup (
      .clk        (clk),
      .rst_n      (rst_n),
      .cycle_done (done),
      .init_busy  (init_busy),
      .ready      (ready)
   );

   rfsh_interval #(
      .REFI_CYC (REFI_CYC)
   ) u_interval (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (ready),
      .tick  (tick)
   );

   rfsh_credit #(
      .MAX_CREDIT (MAX_CREDIT)
   ) u_credit (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .take    (take),
      .pending (pending),
      .overrun (overrun)
   );

   rfsh_cbr_fsm #(
      .SETUP_CYC (SETUP_CYC),
      .RAS_CYC   (RAS_CYC),
      .PRE_CYC   (PRE_CYC)
   ) u_fsm (
      .clk   (clk),
      .rst_n (rst_n),
      .want  (want),
      .gnt   (refresh_gnt),
      .req   (refresh_req),
      .ras_n (ras_n),
      .cas_n (cas_n),
      .start (start),
      .done  (done)
   );

endmodule

// File: rtl/dram_rfsh_chk.sv
module dram_rfsh_chk #(
   parameter int RAS_CYC = 6,
   parameter int PRE_CYC = 4
) (
   input logic clk,
   input logic rst_n,
   input logic ras_n,
   input logic cas_n,
   input logic refresh_req,
   input logic ready,
   input logic overrun
);
   localparam int LW = $clog2(RAS_CYC + 2);
   localparam int HW = $clog2(PRE_CYC + 1);

   logic [LW-1:0] lo_cnt;
   logic [HW-1:0] hi_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lo_cnt <= '0;
         hi_cnt <= '0;
      end else if (!ras_n) begin
         hi_cnt <= '0;
         if (lo_cnt != LW'(RAS_CYC + 1)) lo_cnt <= lo_cnt + LW'(1);
      end else begin
         lo_cnt <= '0;
         if (hi_cnt != HW'(PRE_CYC)) hi_cnt <= hi_cnt + HW'(1);
      end
   end

   // R4
   cas_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ras_n) |-> ($past(cas_n) == 1'b0));

   // R5
   cas_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ras_n |-> !cas_n);

   // R5
   ras_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ras_n) |-> (lo_cnt == LW'(RAS_CYC)));

   // R6
   precharge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ras_n) |-> (hi_cnt == HW'(PRE_CYC)));

   // R7
   cas_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ras_n) |-> cas_n);

   // R9
   bus_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ras_n || !cas_n) |-> refresh_req);

   // R3
   ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ready) |-> ready);

   // R12
   overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(overrun) |-> overrun);

endmodule

bind dram_rfsh_seq dram_rfsh_chk #(
   .RAS_CYC (RAS_CYC),
   .PRE_CYC (PRE_CYC)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .ras_n       (ras_n),
   .cas_n       (cas_n),
   .refresh_req (refresh_req),
   .ready       (ready),
   .overrun     (overrun)
);

// File: tb/tb_dram_rfsh_seq.sv
module tb_dram_rfsh_seq;
   localparam int CLK_PERIOD = 10;
   localparam int CLK_MHZ    = 1000 / CLK_PERIOD;
   localparam int PWRUP_CYC  = 20000;
   localparam int REFI_CYC   = 1560;
   localparam int RAS_CYC    = 6;
   localparam int PRE_CYC    = 4;
   localparam int INIT_N     = 8;
   localparam int MAX_CRED   = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic refresh_gnt = 1'b0;
   logic refresh_req, ras_n, cas_n, we_n, ready, overrun;

   always #(CLK_PERIOD / 2) clk = ~clk;

   dram_rfsh_seq #(.CLK_MHZ(CLK_MHZ)) dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .refresh_gnt (refresh_gnt),
      .refresh_req (refresh_req),
      .ras_n       (ras_n),
      .cas_n       (cas_n),
      .we_n        (we_n),
      .ready       (ready),
      .overrun     (overrun)
   );

   int checks = 0;
   int fails = 0;
   int cyc = 0;
   int release_cyc = 0;
   int exp_q[$];
   int fall_count = 0;
   int last_fall_cyc = 0;
   int we_low = 0;
   int cas_hold_bad = 0;
   int lo_run = 0;
   int hi_run = 0;
   int cur_exp = 0;
   bit prev_ras = 1'b1;
   bit prev_cas = 1'b1;
   bit seen_fall = 1'b0;
   bit finished = 1'b0;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic push_expected();
      exp_q.push_back(RAS_CYC);
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", checks - fails, checks);
   endtask

   task automatic wait_cyc(input int n);
      while (cyc < n) begin
         @(negedge clk);
         #1;
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) cyc <= 0;
      else        cyc <= cyc + 1;
   end

   // grant responder and scoreboard driver
   always @(negedge clk) begin
      bit g;
      g = rst_n && refresh_req && (cyc >= release_cyc);
      if (g && !refresh_gnt) push_expected();
      refresh_gnt = g;
   end

   // pin monitor: pops the scoreboard on each row pulse
   always @(negedge clk) begin
      if (rst_n) begin
         if (we_n !== 1'b1) we_low++;
         if (prev_cas && !cas_n && seen_fall)
            check(hi_run >= 1, "R7 cas fall after ras rise (cycles)", hi_run, 1);
         if (prev_ras && !ras_n) begin
            fall_count++;
            last_fall_cyc = cyc;
            check(prev_cas == 1'b0, "R4 cas low before ras fall", int'(prev_cas), 0);
            if (seen_fall)
               check(hi_run >= PRE_CYC, "R6 ras high between pulses", hi_run, PRE_CYC);
            seen_fall = 1'b1;
            if (exp_q.size() == 0) begin
               check(1'b0, "R9 row pulse without grant", 0, 1);
               cur_exp = RAS_CYC;
            end else begin
               cur_exp = exp_q.pop_front();
            end
            lo_run = 0;
         end
         if (!prev_ras && ras_n) begin
            check(lo_run == cur_exp, "R5 ras low width", lo_run, cur_exp);
            check(cas_n == 1'b1, "R7 cas high at ras rise", int'(cas_n), 1);
            hi_run = 0;
         end
         if (!ras_n) begin
            lo_run++;
            if (cas_n) cas_hold_bad++;
         end else begin
            hi_run++;
         end
         prev_ras = ras_n;
         prev_cas = cas_n;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
         summary();
         $finish;
      end
   end

   initial begin
      int first_req, f1, f2, f3, base, x;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      #1;
      // R1 reset state
      check(ras_n == 1'b1, "R1 ras_n in reset", int'(ras_n), 1);
      check(cas_n == 1'b1, "R1 cas_n in reset", int'(cas_n), 1);
      check(we_n == 1'b1, "R1 we_n in reset", int'(we_n), 1);
      check(refresh_req == 1'b0, "R1 refresh_req in reset", int'(refresh_req), 0);
      check(ready == 1'b0, "R1 ready in reset", int'(ready), 0);
      check(overrun == 1'b0, "R1 overrun in reset", int'(overrun), 0);
      @(negedge clk);
      rst_n = 1'b1;

      // R2 power-up wait
      while (!refresh_req) begin
         @(negedge clk);
         #1;
      end
      first_req = cyc;
      check(first_req >= PWRUP_CYC && first_req <= PWRUP_CYC + 3,
            "R2 first request cycle", first_req, PWRUP_CYC);
      check(fall_count == 0, "R2 no ras pulse during wait", fall_count, 0);

      // R3 initialization burst
      while (!ready) begin
         check(fall_count <= INIT_N, "R3 pulses while not ready", fall_count, INIT_N);
         @(negedge clk);
         #1;
      end
      check(fall_count == INIT_N, "R3 pulses before ready", fall_count, INIT_N);

      // R10 periodic spacing
      base = fall_count;
      while (fall_count < base + 1) begin @(negedge clk); #1; end
      f1 = last_fall_cyc;
      while (fall_count < base + 2) begin @(negedge clk); #1; end
      f2 = last_fall_cyc;
      check(f2 - f1 == REFI_CYC, "R10 refresh spacing", f2 - f1, REFI_CYC);
      while (fall_count < base + 3) begin @(negedge clk); #1; end
      f3 = last_fall_cyc;
      check(f3 - f2 == REFI_CYC, "R10 refresh spacing", f3 - f2, REFI_CYC);
      check(ready == 1'b1, "R3 ready stays high", int'(ready), 1);

      // R11 tick coinciding with grant acceptance
      x = f3 - 3 + 9 * REFI_CYC;
      release_cyc = x - 1;
      base = fall_count;
      wait_cyc(x - 2);
      check(fall_count == base, "R9 no pulse while grant withheld", fall_count - base, 0);
      check(refresh_req == 1'b1, "R9 request held while waiting", int'(refresh_req), 1);
      check(overrun == 1'b0, "R11 eight owed without error", int'(overrun), 0);
      wait_cyc(x + 1);
      check(overrun == 1'b0, "R11 tick with acceptance", int'(overrun), 0);
      wait_cyc(x + 170);
      check(fall_count - base == MAX_CRED + 1, "R11 pulses after release",
            fall_count - base, MAX_CRED + 1);
      check(overrun == 1'b0, "R11 no overrun after drain", int'(overrun), 0);

      // R12 overrun
      wait_cyc(x + 200);
      release_cyc = x + 15800;
      base = fall_count;
      wait_cyc(x + 8 * REFI_CYC + 50);
      check(overrun == 1'b0, "R11 credit full, no error", int'(overrun), 0);
      wait_cyc(x + 9 * REFI_CYC + 50);
      check(overrun == 1'b1, "R12 overrun on ninth tick", int'(overrun), 1);
      check(fall_count == base, "R9 no pulse while grant withheld", fall_count - base, 0);
      wait_cyc(x + 15800 + 200);
      check(fall_count - base == MAX_CRED, "R12 credit saturated", fall_count - base, MAX_CRED);
      check(overrun == 1'b1, "R12 overrun sticky", int'(overrun), 1);

      check(we_low == 0, "R8 we_n low samples", we_low, 0);
      check(cas_hold_bad == 0, "R5 cas high during ras low", cas_hold_bad, 0);
      check(exp_q.size() == 0, "R9 grants without pulse", exp_q.size(), 0);

      finished = 1'b1;
      summary();
      $finish;
   end

endmodule